// File: doc/BRIEF.md
# Keyboard and Display Device Registers

This block is a bus slave that claims four word addresses at the top of a 16-bit address space. Two of these addresses form a keyboard pair: a status word with a ready flag and software-owned control bits, and a data word holding the most recent character. The other two form a display pair: a status word that always reports ready, and a data word whose low byte is sent out on a single-cycle strobe. Every access that misses the four addresses is flagged for ordinary memory in the same cycle.

A receiver presents each incoming character with a one-cycle `key_valid`. A two-state keyboard machine tracks whether a character is waiting. On every arrival the machine raises a one-cycle interrupt request at a fixed vector and priority, but only if the enable bit is set. Reads return data one cycle after the request, which matches the read latency of the memory beside the block.

Keyboard machine states: `KB_EMPTY` (no character waiting) and `KB_FULL` (a character is waiting). Transitions: `ARRIVE` moves `KB_EMPTY` to `KB_FULL` on `key_valid`. `CONSUME` moves `KB_FULL` to `KB_EMPTY` on a read of keyboard data with no arrival in the same cycle. `REFILL` keeps `KB_FULL` when a new character arrives, and the new character overwrites the old one. `IDLE` leaves the state unchanged.

Top module: `kbd_disp_regs`

## Requirements
- R1: `dev_sel` is high in the same cycle when `bus_valid` is high and `bus_addr` is 0xFE00 (keyboard status), 0xFE02 (keyboard data), 0xFE04 (display status) or 0xFE06 (display data). `mem_sel` equals `bus_valid` with `dev_sel` low. Both are combinational.
- R2: After reset, keyboard status reads 0x0000, keyboard data reads 0x0000, display status reads 0x8000 and display data reads 0x0000. `disp_valid`, `irq_req` and `rd_data` are low.
- R3: A read of a device address (`bus_we` low) puts that register's value on `rd_data` in the next cycle. The value is the one held before that clock edge. Any other access leaves `rd_data` at zero in the next cycle.
- R4: On `key_valid`, keyboard data loads `key_char` zero-extended to 16 bits, and keyboard status bit 15 becomes 1.
- R5: A read of keyboard data clears keyboard status bit 15, unless `key_valid` is high in the same cycle. In that case the bit stays 1.
- R6: A write to keyboard status replaces bits [14:0] with the written data. Bit 15 keeps its value, or becomes 1 if a key arrives in the same cycle.
- R7: Writes to keyboard data and to display status change no readable value.
- R8: A write to display data stores the full word, which can be read back. In the next cycle it drives `disp_valid` high for one cycle, with the low 8 bits of the written word on `disp_char`.
- R9: `irq_req` is high for one cycle, in the cycle after `key_valid`, exactly when keyboard status bit 14 was 1 before that edge. `irq_vector` is always 0x80 and `irq_level` is always 4.
- R10: Accesses to any other address change no device register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_valid | input | 1 | Bus access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Word address |
| bus_wdata | input | 16 | Write data |
| dev_sel | output | 1 | Access hits a device register |
| mem_sel | output | 1 | Access passes through to memory |
| rd_data | output | 16 | Read data, one cycle after the request |
| key_valid | input | 1 | Character arrival strobe |
| key_char | input | 8 | Arriving character |
| disp_valid | output | 1 | Display byte strobe |
| disp_char | output | 8 | Display byte |
| irq_req | output | 1 | Keyboard interrupt request pulse |
| irq_vector | output | 8 | Interrupt vector |
| irq_level | output | 3 | Interrupt priority |

## Verification
A key can arrive in the same cycle that software writes keyboard status or reads keyboard data. Both paths update the ready flag, and the arrival must win. The bench forces both collisions with directed cases. Its random phase also overlaps arrivals with bus accesses to every device address. A bench model applies the arrival-wins rule, and each following read is compared against that model.

// File: rtl/kdr_pkg.sv
package kdr_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 16;
    localparam int CHAR_W = 8;
    localparam int NDEV   = 4;

    // Register slot indices; order matches the address table below.
    localparam int SLOT_KSTAT = 0;
    localparam int SLOT_KDATA = 1;
    localparam int SLOT_DSTAT = 2;
    localparam int SLOT_DDATA = 3;

    localparam logic [ADDR_W-1:0] DEV_ADDR [NDEV] = '{16'hFE00, 16'hFE02, 16'hFE04, 16'hFE06};

    localparam int READY_BIT  = DATA_W - 1;
    localparam int ENABLE_BIT = DATA_W - 2;

    typedef enum logic {KB_EMPTY = 1'b0, KB_FULL = 1'b1} kb_state_t;
endpackage

// File: rtl/kdr_decode.sv
module kdr_decode
    import kdr_pkg::*;
(
    input  logic              bus_valid,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic [NDEV-1:0]   rd_sel,
    output logic [NDEV-1:0]   wr_sel,
    output logic              hit
);
    logic [NDEV-1:0] match;

    for (genvar i = 0; i < NDEV; i++) begin : g_match
        assign match[i] = (bus_addr == DEV_ADDR[i]);
    end

    always_comb begin
        hit    = bus_valid && (|match);
        rd_sel = (bus_valid && !bus_we) ? match : '0;
        wr_sel = (bus_valid &&  bus_we) ? match : '0;
    end

    // R1
    sel_onehot_chk: assert final ($onehot0(match));
endmodule

// File: rtl/kdr_kbd.sv
module kdr_kbd
    import kdr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_valid,
    input  logic [CHAR_W-1:0] key_char,
    input  logic              wr_stat,
    input  logic              rd_data,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] stat_word,
    output logic [DATA_W-1:0] data_word,
    output logic              irq_req
);
    kb_state_t state_q, state_d;
    logic [DATA_W-2:0] ctl_q;
    logic [CHAR_W-1:0] char_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            KB_EMPTY: if (key_valid) state_d = KB_FULL;
            KB_FULL:  if (rd_data && !key_valid) state_d = KB_EMPTY;
            default:  state_d = KB_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= KB_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q   <= '0;
            char_q  <= '0;
            irq_req <= 1'b0;
        end else begin
            if (wr_stat)   ctl_q  <= wdata[DATA_W-2:0];
            if (key_valid) char_q <= key_char;
            irq_req <= key_valid && ctl_q[ENABLE_BIT];
        end
    end

    assign stat_word = {(state_q == KB_FULL), ctl_q};
    assign data_word = {{(DATA_W-CHAR_W){1'b0}}, char_q};

    // R4
    ready_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |=> stat_word[READY_BIT]);
    // R5
    ready_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && !key_valid) |=> !stat_word[READY_BIT]);
    // R6
    ready_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && !rd_data && !key_valid) |=> $stable(stat_word[READY_BIT]));
    // R9
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> $past(key_valid));
endmodule

// File: rtl/kdr_disp.sv
module kdr_disp
    import kdr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_data,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] data_word,
    output logic              disp_valid,
    output logic [CHAR_W-1:0] disp_char
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_word  <= '0;
            disp_valid <= 1'b0;
        end else begin
            disp_valid <= wr_data;
            if (wr_data) data_word <= wdata;
        end
    end

    assign disp_char = data_word[CHAR_W-1:0];

    // R8
    disp_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> $past(wr_data));
endmodule

// File: rtl/kbd_disp_regs.sv
module kbd_disp_regs
    import kdr_pkg::*;
#(
    parameter logic [7:0] IRQ_VEC = 8'h80,
    parameter logic [2:0] IRQ_PRI = 3'd4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              dev_sel,
    output logic              mem_sel,
    output logic [DATA_W-1:0] rd_data,
    input  logic              key_valid,
    input  logic [CHAR_W-1:0] key_char,
    output logic              disp_valid,
    output logic [CHAR_W-1:0] disp_char,
    output logic              irq_req,
    output logic [7:0]        irq_vector,
    output logic [2:0]        irq_level
);
    localparam logic [DATA_W-1:0] DSTAT_VAL = DATA_W'(1) << READY_BIT;

    logic [NDEV-1:0]   rd_sel, wr_sel;
    logic [DATA_W-1:0] kstat_w, kdata_w, ddata_w, rd_mux;

    kdr_decode u_dec (
        .bus_valid(bus_valid), .bus_we(bus_we), .bus_addr(bus_addr),
        .rd_sel(rd_sel), .wr_sel(wr_sel), .hit(dev_sel)
    );

    kdr_kbd u_kbd (
        .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key_char(key_char),
        .wr_stat(wr_sel[SLOT_KSTAT]), .rd_data(rd_sel[SLOT_KDATA]),
        .wdata(bus_wdata), .stat_word(kstat_w), .data_word(kdata_w),
        .irq_req(irq_req)
    );

    kdr_disp u_disp (
        .clk(clk), .rst_n(rst_n), .wr_data(wr_sel[SLOT_DDATA]),
        .wdata(bus_wdata), .data_word(ddata_w),
        .disp_valid(disp_valid), .disp_char(disp_char)
    );

    assign mem_sel    = bus_valid && !dev_sel;
    assign irq_vector = IRQ_VEC;
    assign irq_level  = IRQ_PRI;

    always_comb begin
        rd_mux = '0;
        unique case (1'b1)
            rd_sel[SLOT_KSTAT]: rd_mux = kstat_w;
            rd_sel[SLOT_KDATA]: rd_mux = kdata_w;
            rd_sel[SLOT_DSTAT]: rd_mux = DSTAT_VAL;
            rd_sel[SLOT_DDATA]: rd_mux = ddata_w;
            default:            rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_data <= '0;
        else        rd_data <= rd_mux;
    end

    // R1
    route_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> (dev_sel ^ mem_sel));
    // R3
    rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && !bus_we) |=> (rd_data == '0));
endmodule

// File: tb/kbd_disp_regs_test.sv
module kbd_disp_regs_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_valid = 1'b0, bus_we = 1'b0;
    logic [15:0] bus_addr = '0, bus_wdata = '0;
    logic dev_sel, mem_sel, disp_valid, irq_req;
    logic [15:0] rd_data;
    logic key_valid = 1'b0;
    logic [7:0] key_char = '0, disp_char, irq_vector;
    logic [2:0] irq_level;

    int checks = 0, fails = 0;
    bit done = 0;

    logic        m_ready;
    logic [14:0] m_ctl;
    logic [15:0] m_kdata, m_ddata;

    always #(CLK_PERIOD/2) clk = ~clk;

    kbd_disp_regs uut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .dev_sel(dev_sel),
        .mem_sel(mem_sel), .rd_data(rd_data), .key_valid(key_valid),
        .key_char(key_char), .disp_valid(disp_valid), .disp_char(disp_char),
        .irq_req(irq_req), .irq_vector(irq_vector), .irq_level(irq_level)
    );

    function automatic bit is_dev(input logic [15:0] a);
        return a == 16'hFE00 || a == 16'hFE02 || a == 16'hFE04 || a == 16'hFE06;
    endfunction

    function automatic logic [15:0] model_read(input logic [15:0] a);
        case (a)
            16'hFE00: return {m_ready, m_ctl};
            16'hFE02: return m_kdata;
            16'hFE04: return 16'h8000;
            16'hFE06: return m_ddata;
            default:  return 16'h0000;
        endcase
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One bus/key cycle: drive at negedge, check combinational routing,
    // update the model, then check registered outputs after the edge.
    task automatic step(input bit v, input bit we, input logic [15:0] a,
                        input logic [15:0] wd, input bit kv, input logic [7:0] kc);
        logic [15:0] exp_rd;
        bit exp_disp, exp_irq;
        @(negedge clk);
        bus_valid = v; bus_we = we; bus_addr = a; bus_wdata = wd;
        key_valid = kv; key_char = kc;
        #1;
        check("R1 dev_sel", {15'd0, dev_sel}, {15'd0, v && is_dev(a)});
        check("R1 mem_sel", {15'd0, mem_sel}, {15'd0, v && !is_dev(a)});
        exp_rd   = (v && !we) ? model_read(a) : 16'h0;
        exp_disp = v && we && a == 16'hFE06;
        exp_irq  = kv && m_ctl[14];
        if (v && !we && a == 16'hFE02) m_ready = 1'b0;
        if (kv) begin m_ready = 1'b1; m_kdata = {8'h00, kc}; end
        if (v && we && a == 16'hFE00) m_ctl = wd[14:0];
        if (exp_disp) m_ddata = wd;
        @(posedge clk);
        #1;
        check("R3 rd_data", rd_data, exp_rd);
        check("R8 disp_valid", {15'd0, disp_valid}, {15'd0, exp_disp});
        if (exp_disp) check("R8 disp_char", {8'h0, disp_char}, {8'h0, wd[7:0]});
        check("R9 irq_req", {15'd0, irq_req}, {15'd0, exp_irq});
    endtask

    task automatic rd_expect(input string req, input logic [15:0] a, input logic [15:0] exp);
        step(1, 0, a, 16'h0, 0, 8'h0);
        check(req, rd_data, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        m_ready = 0; m_ctl = '0; m_kdata = '0; m_ddata = '0;
        repeat (3) @(posedge clk);
        #1;
        check("R2 disp_valid reset", {15'd0, disp_valid}, 16'h0);
        check("R2 irq_req reset", {15'd0, irq_req}, 16'h0);
        check("R2 rd_data reset", rd_data, 16'h0);
        rst_n = 1'b1;
        check("R9 irq_vector", {8'h0, irq_vector}, 16'h0080);
        check("R9 irq_level", {13'h0, irq_level}, 16'h0004);
        rd_expect("R2 kstat", 16'hFE00, 16'h0000);
        rd_expect("R2 kdata", 16'hFE02, 16'h0000);
        rd_expect("R2 dstat", 16'hFE04, 16'h8000);
        rd_expect("R2 ddata", 16'hFE06, 16'h0000);

        // R4 arrival with interrupts disabled, then R5 consume
        step(0, 0, 16'h0, 16'h0, 1, 8'hC5);
        rd_expect("R4 kstat ready", 16'hFE00, 16'h8000);
        rd_expect("R4 kdata char", 16'hFE02, 16'h00C5);
        rd_expect("R5 ready cleared", 16'hFE00, 16'h0000);

        // R6 write keeps bit 15, R9 enabled interrupt
        step(1, 1, 16'hFE00, 16'hFFFF, 0, 8'h0);
        rd_expect("R6 kstat write", 16'hFE00, 16'h7FFF);
        step(0, 0, 16'h0, 16'h0, 1, 8'h41);
        step(1, 1, 16'hFE00, 16'h4000, 0, 8'h0);
        rd_expect("R6 ready kept", 16'hFE00, 16'hC000);

        // Collisions: status write with arrival; data read with arrival
        step(1, 1, 16'hFE00, 16'h0000, 1, 8'h7E);
        rd_expect("R6 arrival wins write", 16'hFE00, 16'h8000);
        step(1, 0, 16'hFE02, 16'h0, 1, 8'h33);
        check("R5 old char read", rd_data, 16'h007E);
        rd_expect("R5 arrival wins read", 16'hFE00, 16'h8000);

        // R7 ignored writes
        step(1, 1, 16'hFE02, 16'hABCD, 0, 8'h0);
        step(1, 1, 16'hFE04, 16'h0000, 0, 8'h0);
        rd_expect("R7 kdata unchanged", 16'hFE02, 16'h0033);
        rd_expect("R7 dstat unchanged", 16'hFE04, 16'h8000);

        // R8 display writes, back to back
        step(1, 1, 16'hFE06, 16'h1234, 0, 8'h0);
        step(1, 1, 16'hFE06, 16'hBEEF, 0, 8'h0);
        rd_expect("R8 ddata word", 16'hFE06, 16'hBEEF);

        // R10 neighbouring addresses
        step(1, 1, 16'hFE01, 16'hFFFF, 0, 8'h0);
        step(1, 1, 16'hFE07, 16'h5555, 0, 8'h0);
        rd_expect("R10 kstat untouched", 16'hFE00, 16'h0000);
        rd_expect("R10 ddata untouched", 16'hFE06, 16'hBEEF);

        // Random mix
        for (int i = 0; i < 2000; i++) begin
            logic [15:0] a;
            int pick = $urandom_range(0, 9);
            if (pick < 6)      a = 16'hFE00 + 16'(2 * $urandom_range(0, 3));
            else if (pick < 8) a = 16'hFE00 + 16'($urandom_range(0, 7));
            else               a = 16'($urandom);
            step($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1, a,
                 16'($urandom), $urandom_range(0, 2) == 0, 8'($urandom));
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule